// File: doc/BRIEF.md
# Per-Node Three-Level Coherence State Controller

This block keeps the coherence state of one cache line for one node of a chip multiprocessor. Each node holds a private first-level cache, a private second-level cache and a slice of a shared second-level cache. The line state is one vector across all three levels. The first-level part takes modified, owned, shared or invalid. The private second-level part takes modified, owned or invalid. The shared slice takes shared or invalid. Only seven combinations of these are legal. The policy is write-invalidate on write-back caches.

Each cycle the block accepts at most one event. The event is a local processor access (read or write), a snooped bus command from another node (shared fetch or exclusive fetch), or a replacement at one cache level. For that event the block raises, in the same cycle, a bus request, a data-supply response or a writeback request, as the event needs. The new state is registered on the next clock edge. An illegal event raises an error flag, suppresses every other output and keeps the state.

Top module: `coh_node_ctrl`

## Requirements
- R1: After an active-low asynchronous reset, state_o reads III (code 0), and bus_vld_o, bus_getx_o, supply_o, wb_o and err_o are all low.
- R2: state_o always shows one of the seven legal codes: III=0, IIS=1, SIS=2, MII=3, IMI=4, OIS=5, IOS=6. Code 7 is never reached.
- R3: A local read (cpu_wr_i=0) in SIS, MII or OIS raises no bus request, and the state does not change.
- R4: A local read in III raises bus_vld_o with bus_getx_o=0 (shared fetch) in the same cycle, and the state becomes SIS on the next edge.
- R5: A local read in IIS, IOS or IMI moves the state to SIS, OIS or MII respectively, with no bus request.
- R6: After a local write the state is MII. A write in MII or IMI raises no bus request. A write in any other state raises bus_vld_o with bus_getx_o=1 (exclusive fetch or upgrade) in the same cycle. bus_getx_o is low whenever bus_vld_o is low.
- R7: A snooped shared fetch (snp_getx_i=0) moves MII to OIS, IMI to IOS and III to IIS, and leaves every other state unchanged.
- R8: A snooped exclusive fetch (snp_getx_i=1) moves every state to III. On any snooped command, supply_o is high in the same cycle exactly when the state is MII, OIS, IMI or IOS.
- R9: A first-level replacement (evict_lvl_i=0) moves MII to IMI, OIS to IOS and SIS to IIS. In any other state it is an error.
- R10: A private second-level replacement (evict_lvl_i=1) in IMI or IOS raises wb_o in the same cycle and moves the state to III. A shared-slice replacement (evict_lvl_i=2) in IIS moves the state to III with no writeback. Any other state, and evict_lvl_i=3, is an error.
- R11: If more than one of cpu_vld_i, snp_vld_i and evict_vld_i is high, or if an R9/R10 error occurs, err_o is high in that cycle. In that cycle bus_vld_o, supply_o and wb_o stay low and the state is held.
- R12: A cycle with no event holds the state and raises no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_vld_i | input | 1 | Local processor access this cycle |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| snp_vld_i | input | 1 | Snooped command from another node this cycle |
| snp_getx_i | input | 1 | 1 = exclusive fetch, 0 = shared fetch |
| evict_vld_i | input | 1 | Replacement event this cycle |
| evict_lvl_i | input | 2 | 0 = first level, 1 = private second level, 2 = shared slice, 3 = reserved |
| state_o | output | 3 | Registered combined line state |
| bus_vld_o | output | 1 | Bus request issued this cycle |
| bus_getx_o | output | 1 | Bus request is an exclusive fetch |
| supply_o | output | 1 | Node supplies data as owner |
| wb_o | output | 1 | Writeback of owned data requested |
| err_o | output | 1 | Illegal event or illegal state |

## Verification
state_o is the register itself, so a wrong transition shows at the port one edge after the event that caused it. After that, every following event is decoded from the corrupted state. A corrupted state therefore also shows in the same cycle as a missing or extra bus request, a missing or extra supply response or writeback, or an error flag where none belongs. Comparing every output on every cycle against a model that tracks the state by its level letters catches a fault at the first event whose response depends on it.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam int unsigned ST_W  = 3;
  localparam int unsigned LVL_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_III = 3'd0,
    ST_IIS = 3'd1,
    ST_SIS = 3'd2,
    ST_MII = 3'd3,
    ST_IMI = 3'd4,
    ST_OIS = 3'd5,
    ST_IOS = 3'd6,
    ST_BAD = 3'd7
  } line_st_e;

  typedef enum logic [LVL_W-1:0] {
    LV_L1  = 2'd0,
    LV_PL2 = 2'd1,
    LV_SL2 = 2'd2,
    LV_RSV = 2'd3
  } evict_lvl_e;

  function automatic logic st_owner(line_st_e s);
    return (s == ST_MII) || (s == ST_OIS) || (s == ST_IMI) || (s == ST_IOS);
  endfunction
endpackage

// File: rtl/coh_cpu_path.sv
module coh_cpu_path
  import coh_pkg::*;
(
  input  line_st_e st_i,
  input  logic     wr_i,
  output line_st_e nxt_o,
  output logic     bus_vld_o,
  output logic     bus_getx_o
);
  always_comb begin
    nxt_o      = st_i;
    bus_vld_o  = 1'b0;
    bus_getx_o = 1'b0;
    if (!wr_i) begin
      unique case (st_i)
        ST_III: begin
          bus_vld_o = 1'b1;
          nxt_o     = ST_SIS;
        end
        ST_IIS:  nxt_o = ST_SIS;
        ST_IOS:  nxt_o = ST_OIS;
        ST_IMI:  nxt_o = ST_MII;
        default: nxt_o = st_i;
      endcase
    end else begin
      unique case (st_i)
        ST_MII:  nxt_o = ST_MII;
        ST_IMI:  nxt_o = ST_MII;  // exclusive owner below, silent promote
        default: begin
          bus_vld_o  = 1'b1;
          bus_getx_o = 1'b1;
          nxt_o      = ST_MII;
        end
      endcase
    end
  end
endmodule

// File: rtl/coh_snoop_path.sv
module coh_snoop_path
  import coh_pkg::*;
(
  input  line_st_e st_i,
  input  logic     getx_i,
  output line_st_e nxt_o,
  output logic     supply_o
);
  always_comb begin
    supply_o = st_owner(st_i);
    nxt_o    = st_i;
    if (getx_i) begin
      nxt_o = ST_III;
    end else begin
      unique case (st_i)
        ST_MII:  nxt_o = ST_OIS;
        ST_IMI:  nxt_o = ST_IOS;
        ST_III:  nxt_o = ST_IIS;
        default: nxt_o = st_i;
      endcase
    end
  end
endmodule

// File: rtl/coh_evict_path.sv
module coh_evict_path
  import coh_pkg::*;
(
  input  line_st_e   st_i,
  input  evict_lvl_e lvl_i,
  output line_st_e   nxt_o,
  output logic       wb_o,
  output logic       bad_o
);
  always_comb begin
    nxt_o = st_i;
    wb_o  = 1'b0;
    bad_o = 1'b0;
    unique case (lvl_i)
      LV_L1: begin
        unique case (st_i)
          ST_MII:  nxt_o = ST_IMI;
          ST_OIS:  nxt_o = ST_IOS;
          ST_SIS:  nxt_o = ST_IIS;
          default: bad_o = 1'b1;
        endcase
      end
      LV_PL2: begin
        if ((st_i == ST_IMI) || (st_i == ST_IOS)) begin
          wb_o  = 1'b1;
          nxt_o = ST_III;
        end else begin
          bad_o = 1'b1;
        end
      end
      LV_SL2: begin
        if (st_i == ST_IIS) nxt_o = ST_III;
        else                bad_o = 1'b1;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/coh_node_ctrl.sv
module coh_node_ctrl
  import coh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_vld_i,
  input  logic             cpu_wr_i,
  input  logic             snp_vld_i,
  input  logic             snp_getx_i,
  input  logic             evict_vld_i,
  input  logic [LVL_W-1:0] evict_lvl_i,
  output logic [ST_W-1:0]  state_o,
  output logic             bus_vld_o,
  output logic             bus_getx_o,
  output logic             supply_o,
  output logic             wb_o,
  output logic             err_o
);
  line_st_e   st_q, st_d;
  line_st_e   cpu_nxt, snp_nxt, ev_nxt;
  logic       cpu_bus, cpu_getx, snp_sup, ev_wb, ev_bad;
  logic       multi_ev, st_bad, any_ev;
  evict_lvl_e lvl;

  assign lvl = evict_lvl_e'(evict_lvl_i);

  coh_cpu_path u_cpu (
    .st_i      (st_q),
    .wr_i      (cpu_wr_i),
    .nxt_o     (cpu_nxt),
    .bus_vld_o (cpu_bus),
    .bus_getx_o(cpu_getx)
  );

  coh_snoop_path u_snp (
    .st_i    (st_q),
    .getx_i  (snp_getx_i),
    .nxt_o   (snp_nxt),
    .supply_o(snp_sup)
  );

  coh_evict_path u_ev (
    .st_i (st_q),
    .lvl_i(lvl),
    .nxt_o(ev_nxt),
    .wb_o (ev_wb),
    .bad_o(ev_bad)
  );

  assign multi_ev = ({1'b0, cpu_vld_i} + {1'b0, snp_vld_i} + {1'b0, evict_vld_i}) > 2'd1;
  assign st_bad   = (st_q == ST_BAD);
  assign any_ev   = cpu_vld_i | snp_vld_i | evict_vld_i;
  assign err_o    = multi_ev | st_bad | (evict_vld_i & ev_bad);

  assign bus_vld_o  = cpu_vld_i & cpu_bus & ~err_o;
  assign bus_getx_o = bus_vld_o & cpu_getx;
  assign supply_o   = snp_vld_i & snp_sup & ~err_o;
  assign wb_o       = evict_vld_i & ev_wb & ~err_o;

  always_comb begin
    st_d = st_q;
    if (any_ev && !err_o) begin
      if (cpu_vld_i)      st_d = cpu_nxt;
      else if (snp_vld_i) st_d = snp_nxt;
      else                st_d = ev_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_III;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

module coh_node_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_vld_i,
  input logic       cpu_wr_i,
  input logic       snp_vld_i,
  input logic       snp_getx_i,
  input logic       evict_vld_i,
  input logic [2:0] state_o,
  input logic       bus_vld_o,
  input logic       bus_getx_o,
  input logic       supply_o,
  input logic       wb_o,
  input logic       err_o
);
  assert_state_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 3'd7);
  assert_read_hit_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_vld_i && !cpu_wr_i && !err_o && (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd5))
    |-> !bus_vld_o);
  assert_read_hit_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_vld_i && !cpu_wr_i && !err_o && (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd5))
    |=> $stable(state_o));
  assert_bus_from_cpu_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_vld_o |-> (cpu_vld_i && !err_o));
  assert_write_to_mii_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_vld_i && cpu_wr_i && !err_o) |=> state_o == 3'd3);
  assert_getx_qualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_getx_o |-> bus_vld_o);
  assert_getx_invalidates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_vld_i && snp_getx_i && !err_o) |=> state_o == 3'd0);
  assert_supply_on_snoop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_o |-> snp_vld_i);
  assert_wb_to_iii_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |=> state_o == 3'd0);
  assert_err_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(state_o));
  assert_err_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(bus_vld_o || supply_o || wb_o));
endmodule

bind coh_node_ctrl coh_node_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_vld_i  (cpu_vld_i),
  .cpu_wr_i   (cpu_wr_i),
  .snp_vld_i  (snp_vld_i),
  .snp_getx_i (snp_getx_i),
  .evict_vld_i(evict_vld_i),
  .state_o    (state_o),
  .bus_vld_o  (bus_vld_o),
  .bus_getx_o (bus_getx_o),
  .supply_o   (supply_o),
  .wb_o       (wb_o),
  .err_o      (err_o)
);

// File: tb/test_coh_node_ctrl.sv
`timescale 1ns/1ps
module test_coh_node_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_vld = 1'b0, cpu_wr = 1'b0, snp_vld = 1'b0, snp_getx = 1'b0, ev_vld = 1'b0;
  logic [1:0] ev_lvl = 2'd0;
  logic [2:0] state;
  logic       bus_vld, bus_getx, supply, wb, err;

  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 0;
  string mst    = "III";

  always #5 clk = ~clk;

  coh_node_ctrl i_coh_node_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_vld_i(cpu_vld), .cpu_wr_i(cpu_wr),
    .snp_vld_i(snp_vld), .snp_getx_i(snp_getx),
    .evict_vld_i(ev_vld), .evict_lvl_i(ev_lvl),
    .state_o(state), .bus_vld_o(bus_vld), .bus_getx_o(bus_getx),
    .supply_o(supply), .wb_o(wb), .err_o(err)
  );

  function automatic logic [2:0] code_of(string s);
    case (s)
      "III": return 3'd0; "IIS": return 3'd1; "SIS": return 3'd2; "MII": return 3'd3;
      "IMI": return 3'd4; "OIS": return 3'd5; "IOS": return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic bit is_owner(string s);
    return (s == "MII") || (s == "OIS") || (s == "IMI") || (s == "IOS");
  endfunction

  // reference model over level letters
  task automatic model(input string st, input bit c, w, s, x, e, input [1:0] l,
                       output string nx, output bit bv, bx, sp, wbk, er, output string tag);
    int n = int'(c) + int'(s) + int'(e);
    nx = st; bv = 0; bx = 0; sp = 0; wbk = 0; er = 0; tag = "R12";
    if (n > 1) begin er = 1; tag = "R11"; return; end
    if (c && !w) begin
      if (st == "III")      begin bv = 1; nx = "SIS"; tag = "R4"; end
      else if (st == "IIS") begin nx = "SIS"; tag = "R5"; end
      else if (st == "IOS") begin nx = "OIS"; tag = "R5"; end
      else if (st == "IMI") begin nx = "MII"; tag = "R5"; end
      else tag = "R3";
    end else if (c) begin
      tag = "R6"; nx = "MII";
      if (st != "MII" && st != "IMI") begin bv = 1; bx = 1; end
    end else if (s) begin
      sp = is_owner(st);
      if (x) begin nx = "III"; tag = "R8"; end
      else begin
        tag = "R7";
        if (st == "MII") nx = "OIS";
        else if (st == "IMI") nx = "IOS";
        else if (st == "III") nx = "IIS";
      end
    end else if (e) begin
      if (l == 2'd0) begin
        tag = "R9";
        if (st == "MII") nx = "IOS" == "" ? "" : "IMI";
        else if (st == "OIS") nx = "IOS";
        else if (st == "SIS") nx = "IIS";
        else er = 1;
      end else begin
        tag = "R10";
        if (l == 2'd1 && (st == "IMI" || st == "IOS")) begin wbk = 1; nx = "III"; end
        else if (l == 2'd2 && st == "IIS") nx = "III";
        else er = 1;
      end
    end
  endtask

  task automatic step(input bit c, w, s, x, e, input [1:0] l);
    string nx, tag;
    bit bv, bx, sp, wbk, er;
    logic [7:0] got, exp;
    @(negedge clk);
    cpu_vld = c; cpu_wr = w; snp_vld = s; snp_getx = x; ev_vld = e; ev_lvl = l;
    #1;
    model(mst, c, w, s, x, e, l, nx, bv, bx, sp, wbk, er, tag);
    got = {state, bus_vld, bus_getx, supply, wb, err};
    exp = {code_of(mst), bv, bx, sp, wbk, er};
    n_vec++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s (R2 state) in %s ev=%b%b%b%b%b%0d: got %b expected %b",
               tag, mst, c, w, s, x, e, l, got, exp);
    end
    @(posedge clk);
    mst = nx;
  endtask

  task automatic check_reset(input string what);
    n_vec++;
    if ({state, bus_vld, bus_getx, supply, wb, err} !== 8'd0) begin
      n_fail++;
      $display("FAIL R1 %s: got %b expected %b", what,
               {state, bus_vld, bus_getx, supply, wb, err}, 8'd0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #23;
    check_reset("during reset");
    @(negedge clk); rst_n = 1'b1;
    #1 check_reset("after release");
    // directed walk: c w s x e lvl
    step(1,0,0,0,0,0); // R4 III read -> SIS
    step(1,0,0,0,0,0); // R3 hit
    step(1,1,0,0,0,0); // R6 upgrade
    step(1,0,0,0,0,0); // R3 hit MII
    step(1,1,0,0,0,0); // R6 MII quiet
    step(0,0,1,0,0,0); // R7 MII -> OIS, supply
    step(1,0,0,0,0,0); // R3 hit OIS
    step(0,0,0,0,1,0); // R9 OIS -> IOS
    step(1,0,0,0,0,0); // R5 IOS -> OIS
    step(0,0,0,0,1,0); // R9
    step(0,0,1,0,0,0); // R7 IOS unchanged, supply
    step(0,0,0,0,1,1); // R10 writeback
    step(0,0,0,0,0,0); // R12 idle
    step(0,0,1,0,0,0); // R7 III -> IIS
    step(1,0,0,0,0,0); // R5 IIS -> SIS
    step(0,0,0,0,1,0); // R9 SIS -> IIS
    step(0,0,0,0,1,2); // R10 shared slice
    step(0,0,0,0,1,0); // R9 error in III
    step(0,0,0,0,1,1); // R10 error in III
    step(0,0,0,0,1,3); // R10 reserved level
    step(1,1,0,0,0,0); // R6 III -> MII
    step(0,0,0,0,1,0); // R9 MII -> IMI
    step(1,1,0,0,0,0); // R6 IMI silent
    step(0,0,0,0,1,0); // R9
    step(0,0,1,0,0,0); // R7 IMI -> IOS
    step(1,1,1,0,0,0); // R11 multi
    step(0,0,1,1,1,0); // R11 multi
    step(0,0,1,1,0,0); // R8 IOS -> III supply
    step(0,0,1,1,0,0); // R8 III no supply
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 9);
      bit a = 1'($urandom), b = 1'($urandom);
      logic [1:0] lv = 2'($urandom);
      case (k)
        0, 1, 2: step(1, a, 0, 0, 0, 0);
        3, 4, 5: step(0, 0, 1, a, 0, 0);
        6, 7:    step(0, 0, 0, 0, 1, lv);
        8:       step(0, 0, 0, 0, 0, 0);
        default: step(1, a, 1, b, a | b, lv);
      endcase
    end
    // asynchronous reset mid-run
    step(1,1,0,0,0,0);
    @(negedge clk);
    cpu_vld = 0; snp_vld = 0; ev_vld = 0;
    #2 rst_n = 1'b0;
    #1 check_reset("async mid-run");
    mst = "III";
    @(negedge clk); rst_n = 1'b1;
    step(1,0,0,0,0,0); // R4 after reset
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule